// File: doc/BRIEF.md
# Out-of-Order Issue Selector with Register Usage Matrices

This block decides, once per clock, which of up to four decoded instructions waiting in a small window may start execution. It targets a machine with eight general registers and three-address instructions. Each waiting instruction is stored as two bit rows, one per register. The read row marks the registers the instruction takes as operands. The write row marks the register it replaces. A pending-write vector marks registers whose new value has not yet arrived.

An instruction is eligible when four things hold. Its functional unit is free. None of its registers is pending. No older waiting instruction writes anything it reads. No older waiting instruction reads or writes what it writes. The block issues at most one eligible instruction per cycle. The issued row is removed, the younger rows move up one place, and the next decoded instruction fills the first free row.

The block also owns the fetch counter. A jump to an explicit address is taken at decode and never occupies a row. A branch that depends on register contents does enter the window, but intake then stops until the branch outcome is reported back.

Top module: `seqmat_sched`

## Requirements
- R1: Each accepted instruction becomes a row. Its read row has bit j set for each enabled source field equal to j. Its write row has bit j set only for an ordinary operation (kind 00 or 11) with the write enable set and destination j. Branches (kind 01) and jumps (kind 10) write nothing.
- R2: `reg_pending[j]` rises on the edge after an issue whose write row has bit j set. It falls on the edge after `cmp_valid` with `cmp_reg`=j. When both happen on the same edge for the same register, the set wins.
- R3: A row is eligible only if `unit_free[unit]` is 1 and `reg_pending` is 0 at every register its read or write row marks.
- R4: A row is not eligible while any older valid row writes a register that it reads.
- R5: A row is not eligible while any older valid row reads or writes a register that it writes.
- R6: If an eligible row holds a branch, that row issues. Otherwise the eligible row nearest the top (slot 0) issues. `iss_slot`, `iss_pc`, `iss_unit` and `iss_is_br` describe the chosen row in the same cycle.
- R7: When no row is eligible, `iss_valid` is 0 and no row leaves the window.
- R8: After an issue, the younger rows shift up one slot with their order kept. An accepted instruction (`dec_valid` and `dec_ready`) takes the first free slot, and `fetch_pc` then increments by one. `dec_ready` is 1 when refill is not halted and fewer than four rows remain after this cycle's issue.
- R9: An accepted jump (kind 10) loads `fetch_pc` with `dec_target` and takes no row.
- R10: Accepting a branch (kind 01) halts refill, so `dec_ready` stays 0. `br_done` ends the halt. At the same edge it loads `fetch_pc` with `br_target` when `br_redirect` is 1, and otherwise leaves `fetch_pc` unchanged.
- R11: Slots at or beyond the valid count take no part in any eligibility or older-row check.
- R12: After synchronous active-low reset the window is empty, `reg_pending` is 0, `fetch_pc` is 0, `iss_valid` is 0 and `dec_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | Decoded instruction offered |
| dec_kind | input | 2 | 00/11 operation, 01 register branch, 10 jump |
| dec_unit | input | 1 | Functional unit class needed |
| dec_rd | input | 3 | Destination register |
| dec_rd_wr | input | 1 | Destination field used |
| dec_rs1 | input | 3 | First source register |
| dec_rs1_en | input | 1 | First source used |
| dec_rs2 | input | 3 | Second source register |
| dec_rs2_en | input | 1 | Second source used |
| dec_target | input | 8 | Jump destination |
| dec_ready | output | 1 | Offered instruction is accepted this cycle |
| fetch_pc | output | 8 | Address of next instruction to decode |
| unit_free | input | 2 | Per-class functional unit availability |
| cmp_valid | input | 1 | A register write has completed |
| cmp_reg | input | 3 | Register whose write completed |
| br_done | input | 1 | Waiting branch has been resolved |
| br_redirect | input | 1 | Resolved branch is taken |
| br_target | input | 8 | Taken-branch destination |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_slot | output | 2 | Window slot of the issued row |
| iss_pc | output | 8 | Fetch address of the issued instruction |
| iss_unit | output | 1 | Unit class of the issued instruction |
| iss_is_br | output | 1 | Issued instruction is a register branch |
| reg_pending | output | 8 | Registers with a write outstanding |

## Verification
The issue outputs and `dec_ready` are combinational on the registered window. They are due in the same cycle as the inputs that affect them. Window contents, `reg_pending` and `fetch_pc` change only at the next rising edge. The bench drives inputs just after a falling edge and samples every output 2 ns later, well before the rising edge. It then advances its own model of the window, the pending vector and the fetch counter by exactly one edge. Each sample is therefore compared with the state that the preceding edge produced.

// File: rtl/seqmat_pkg.sv
// Shared sizing and types for the issue selector.
// Assumes NREG and DEPTH are powers of two and NUNIT is at least 2.
package seqmat_pkg;
    parameter int NREG  = 8;
    parameter int DEPTH = 4;
    parameter int NUNIT = 2;
    parameter int PCW   = 8;

    localparam int RW = $clog2(NREG);
    localparam int UW = $clog2(NUNIT);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef enum logic [1:0] {
        K_OP  = 2'b00,
        K_CBR = 2'b01,
        K_JMP = 2'b10,
        K_OPX = 2'b11
    } kind_e;

    typedef struct packed {
        logic [NREG-1:0] src;
        logic [NREG-1:0] dst;
        logic [UW-1:0]   unit;
        logic            is_br;
        logic [PCW-1:0]  pc;
    } row_t;

    localparam int RB = $bits(row_t);
endpackage

// File: rtl/seqmat_decode.sv
// Turns register fields of one decoded instruction into unary read and
// write rows. Assumes the caller only uses the row for non-jump kinds.
module seqmat_decode
    import seqmat_pkg::*;
(
    input  logic [1:0]     kind,
    input  logic [UW-1:0]  unit,
    input  logic [RW-1:0]  rd,
    input  logic           rd_wr,
    input  logic [RW-1:0]  rs1,
    input  logic           rs1_en,
    input  logic [RW-1:0]  rs2,
    input  logic           rs2_en,
    input  logic [PCW-1:0] pc,
    output row_t           row,
    output logic           is_jump
);
    logic is_op;

    // classify the instruction kind
    always_comb begin
        is_op   = (kind == K_OP) || (kind == K_OPX);
        is_jump = (kind == K_JMP);
    end

    // build one-hot-per-register rows
    always_comb begin
        row       = '0;
        row.unit  = unit;
        row.pc    = pc;
        row.is_br = (kind == K_CBR);
        if (rs1_en) row.src[rs1] = 1'b1;
        if (rs2_en) row.src[rs2] = 1'b1;
        if (is_op && rd_wr) row.dst[rd] = 1'b1;
    end
endmodule

// File: rtl/seqmat_pick.sv
// Evaluates the hazard rules for every window row and selects one row.
// Assumes valid rows form a prefix from slot 0; invalid rows are masked.
module seqmat_pick
    import seqmat_pkg::*;
(
    input  row_t [DEPTH-1:0] rows,
    input  logic [DEPTH-1:0] valid,
    input  logic [NREG-1:0]  busy,
    input  logic [NUNIT-1:0] unit_free,
    output logic             pick_valid,
    output logic [IW-1:0]    pick_idx
);
    logic [DEPTH-1:0][NREG-1:0] older_src;
    logic [DEPTH-1:0][NREG-1:0] older_dst;
    logic [DEPTH-1:0]           elig;
    logic [DEPTH-1:0]           br_elig;
    logic [NREG-1:0]            acc_src;
    logic [NREG-1:0]            acc_dst;

    // accumulate register use of all older valid rows, column by column
    always_comb begin
        acc_src = '0;
        acc_dst = '0;
        for (int i = 0; i < DEPTH; i++) begin
            older_src[i] = acc_src;
            older_dst[i] = acc_dst;
            if (valid[i]) begin
                acc_src = acc_src | rows[i].src;
                acc_dst = acc_dst | rows[i].dst;
            end
        end
    end

    // per-row eligibility from unit, busy and older-row checks
    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        logic unit_ok, busy_ok, raw_ok, wr_ok;
        always_comb begin
            unit_ok    = unit_free[rows[g].unit];
            busy_ok    = ~|(busy & (rows[g].src | rows[g].dst));
            raw_ok     = ~|(older_dst[g] & rows[g].src);
            wr_ok      = ~|((older_src[g] | older_dst[g]) & rows[g].dst);
            elig[g]    = valid[g] && unit_ok && busy_ok && raw_ok && wr_ok;
            br_elig[g] = elig[g] && rows[g].is_br;
        end
    end

    // branch first, else topmost eligible row
    always_comb begin
        pick_valid = |elig;
        pick_idx   = '0;
        if (|br_elig) begin
            for (int i = DEPTH - 1; i >= 0; i--)
                if (br_elig[i]) pick_idx = IW'(i);
        end else begin
            for (int i = DEPTH - 1; i >= 0; i--)
                if (elig[i]) pick_idx = IW'(i);
        end
    end
endmodule

// File: rtl/seqmat_window.sv
// Holds the instruction window: removes the issued row, shifts younger
// rows up and appends the incoming row in the first free slot.
// Assumes the caller never inserts into a full window.
module seqmat_window
    import seqmat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_fire,
    input  logic [IW-1:0]    iss_idx,
    input  logic             ins_fire,
    input  row_t             ins_row,
    output row_t [DEPTH-1:0] rows,
    output logic [DEPTH-1:0] valid,
    output logic [CW-1:0]    cnt,
    output logic [CW-1:0]    cnt_left
);
    row_t [DEPTH-1:0] shifted;
    row_t [DEPTH-1:0] rows_nxt;

    // valid mask and occupancy after this cycle's issue
    always_comb begin
        for (int i = 0; i < DEPTH; i++) valid[i] = (CW'(i) < cnt);
        cnt_left = cnt - CW'(iss_fire);
        shifted  = rows >> RB;
    end

    // compaction followed by append
    always_comb begin
        rows_nxt = rows;
        for (int i = 0; i < DEPTH; i++)
            if (iss_fire && (IW'(i) >= iss_idx)) rows_nxt[i] = shifted[i];
        if (ins_fire) rows_nxt[cnt_left[IW-1:0]] = ins_row;
    end

    // window state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rows <= '0;
            cnt  <= '0;
        end else begin
            rows <= rows_nxt;
            cnt  <= cnt_left + CW'(ins_fire);
        end
    end
endmodule

// File: rtl/seqmat_busy.sv
// Pending-write vector: set by issue, cleared by completion, set wins.
module seqmat_busy
    import seqmat_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREG-1:0] set_vec,
    input  logic            clr_valid,
    input  logic [RW-1:0]   clr_reg,
    output logic [NREG-1:0] busy
);
    logic [NREG-1:0] clr_vec;

    // one-hot of the completing register
    always_comb clr_vec = clr_valid ? (NREG'(1) << clr_reg) : '0;

    // update pending bits
    always_ff @(posedge clk) begin
        if (!rst_n) busy <= '0;
        else        busy <= (busy & ~clr_vec) | set_vec;
    end
endmodule

// File: rtl/seqmat_sched.sv
// Top of the issue selector: decode to rows, window, picker, pending
// vector, fetch counter and branch refill halt.
// Assumes br_done is only raised while a register branch is outstanding.
module seqmat_sched
    import seqmat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid,
    input  logic [1:0]       dec_kind,
    input  logic [UW-1:0]    dec_unit,
    input  logic [RW-1:0]    dec_rd,
    input  logic             dec_rd_wr,
    input  logic [RW-1:0]    dec_rs1,
    input  logic             dec_rs1_en,
    input  logic [RW-1:0]    dec_rs2,
    input  logic             dec_rs2_en,
    input  logic [PCW-1:0]   dec_target,
    output logic             dec_ready,
    output logic [PCW-1:0]   fetch_pc,
    input  logic [NUNIT-1:0] unit_free,
    input  logic             cmp_valid,
    input  logic [RW-1:0]    cmp_reg,
    input  logic             br_done,
    input  logic             br_redirect,
    input  logic [PCW-1:0]   br_target,
    output logic             iss_valid,
    output logic [IW-1:0]    iss_slot,
    output logic [PCW-1:0]   iss_pc,
    output logic [UW-1:0]    iss_unit,
    output logic             iss_is_br,
    output logic [NREG-1:0]  reg_pending
);
    row_t             new_row;
    logic             new_jump;
    row_t [DEPTH-1:0] rows;
    logic [DEPTH-1:0] valid;
    logic [CW-1:0]    win_cnt;
    logic [CW-1:0]    cnt_left;
    logic [NREG-1:0]  iss_dst;
    logic             accept;
    logic             ins_fire;
    logic             refill_hold;
    row_t             sel_row;

    seqmat_decode u_dec (
        .kind   (dec_kind),
        .unit   (dec_unit),
        .rd     (dec_rd),
        .rd_wr  (dec_rd_wr),
        .rs1    (dec_rs1),
        .rs1_en (dec_rs1_en),
        .rs2    (dec_rs2),
        .rs2_en (dec_rs2_en),
        .pc     (fetch_pc),
        .row    (new_row),
        .is_jump(new_jump)
    );

    seqmat_pick u_pick (
        .rows      (rows),
        .valid     (valid),
        .busy      (reg_pending),
        .unit_free (unit_free),
        .pick_valid(iss_valid),
        .pick_idx  (iss_slot)
    );

    seqmat_window u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .iss_fire(iss_valid),
        .iss_idx (iss_slot),
        .ins_fire(ins_fire),
        .ins_row (new_row),
        .rows    (rows),
        .valid   (valid),
        .cnt     (win_cnt),
        .cnt_left(cnt_left)
    );

    seqmat_busy u_busy (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (iss_dst),
        .clr_valid(cmp_valid),
        .clr_reg  (cmp_reg),
        .busy     (reg_pending)
    );

    // issue fields of the chosen row
    always_comb begin
        sel_row   = rows[iss_slot];
        iss_pc    = sel_row.pc;
        iss_unit  = sel_row.unit;
        iss_is_br = sel_row.is_br;
        iss_dst   = iss_valid ? sel_row.dst : '0;
    end

    // intake handshake
    always_comb begin
        dec_ready = !refill_hold && (cnt_left < CW'(DEPTH));
        accept    = dec_valid && dec_ready;
        ins_fire  = accept && !new_jump;
    end

    // fetch counter and branch refill halt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_pc    <= '0;
            refill_hold <= 1'b0;
        end else if (refill_hold) begin
            if (br_done) begin
                refill_hold <= 1'b0;
                if (br_redirect) fetch_pc <= br_target;
            end
        end else if (accept) begin
            fetch_pc    <= new_jump ? dec_target : fetch_pc + 1'b1;
            refill_hold <= new_row.is_br;
        end
    end
endmodule

// File: rtl/seqmat_sched_chk.sv
// Property checker bound to the issue selector.
module seqmat_sched_chk
    import seqmat_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             iss_valid,
    input logic [UW-1:0]    iss_unit,
    input logic [NUNIT-1:0] unit_free,
    input logic [NREG-1:0]  iss_dst,
    input logic [NREG-1:0]  reg_pending,
    input logic             cmp_valid,
    input logic [RW-1:0]    cmp_reg,
    input logic             refill_hold,
    input logic             dec_ready,
    input logic             dec_valid,
    input logic [1:0]       dec_kind,
    input logic [PCW-1:0]   dec_target,
    input logic [PCW-1:0]   fetch_pc,
    input logic [CW-1:0]    win_cnt
);
    logic ins_now;
    always_comb ins_now = dec_valid && dec_ready && (dec_kind != K_JMP);

    assert_reset_clean_R12: assert property (@(posedge clk)
        !rst_n |=> (reg_pending == '0 && fetch_pc == '0 && win_cnt == '0));

    assert_unit_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> unit_free[iss_unit]);

    assert_pending_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |=> ((reg_pending & $past(iss_dst)) == $past(iss_dst)));

    assert_pending_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !iss_dst[cmp_reg]) |=> !reg_pending[$past(cmp_reg)]);

    assert_hold_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        refill_hold |-> !dec_ready);

    assert_jump_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_ready && dec_kind == K_JMP) |=> (fetch_pc == $past(dec_target)));

    assert_idle_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!iss_valid && !ins_now) |=> (win_cnt == $past(win_cnt)));

    assert_issue_removes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !ins_now) |=> (win_cnt == $past(win_cnt) - 1'b1));
endmodule

bind seqmat_sched seqmat_sched_chk u_chk (.*);

// File: tb/seqmat_sched_test.sv
`timescale 1ns/1ps
module seqmat_sched_test;
    import seqmat_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dec_valid = 0, dec_rd_wr = 0, dec_rs1_en = 0, dec_rs2_en = 0;
    logic [1:0] dec_kind = 0;
    logic [UW-1:0] dec_unit = 0;
    logic [RW-1:0] dec_rd = 0, dec_rs1 = 0, dec_rs2 = 0;
    logic [PCW-1:0] dec_target = 0, br_target = 0;
    logic [NUNIT-1:0] unit_free = 0;
    logic cmp_valid = 0, br_done = 0, br_redirect = 0;
    logic [RW-1:0] cmp_reg = 0;
    logic dec_ready, iss_valid, iss_is_br;
    logic [PCW-1:0] fetch_pc, iss_pc;
    logic [IW-1:0] iss_slot;
    logic [UW-1:0] iss_unit;
    logic [NREG-1:0] reg_pending;

    seqmat_sched uut (.*);

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model state
    logic [NREG-1:0] m_src [DEPTH];
    logic [NREG-1:0] m_dst [DEPTH];
    logic [UW-1:0]   m_unit [DEPTH];
    logic            m_br [DEPTH];
    logic [PCW-1:0]  m_pc [DEPTH];
    int              m_cnt;
    logic [NREG-1:0] m_busy;
    logic [PCW-1:0]  m_fpc;
    bit              m_hold, m_brx;
    bit              e_v;
    int              e_i;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected pick from the hazard rules (R1,R3,R4,R5,R6,R11)
    task automatic model_pick();
        bit el, br_hit;
        e_v = 0; e_i = 0; br_hit = 0;
        for (int i = 0; i < m_cnt; i++) begin
            el = unit_free[m_unit[i]] && ((m_busy & (m_src[i] | m_dst[i])) == 0);
            for (int j = 0; j < i; j++) begin
                if ((m_dst[j] & m_src[i]) != 0) el = 0;
                if (((m_src[j] | m_dst[j]) & m_dst[i]) != 0) el = 0;
            end
            if (el && m_br[i] && !br_hit) begin br_hit = 1; e_v = 1; e_i = i; end
            else if (el && !e_v) begin e_v = 1; e_i = i; end
        end
    endtask

    // one cycle: drive, sample, advance model
    task automatic step(input int span, input int bpct);
        bit acc, exp_rdy;
        int r, k;
        logic [NREG-1:0] nsrc, ndst, clr;
        @(negedge clk);
        dec_valid  = ($urandom_range(7) != 0);
        k          = $urandom_range(99);
        dec_kind   = (k < bpct) ? 2'b01 : (k < 2 * bpct) ? 2'b10 : 2'($urandom_range(1)) * 2'b11;
        dec_unit   = UW'($urandom_range(NUNIT - 1));
        dec_rd     = RW'($urandom_range(span - 1));
        dec_rs1    = RW'($urandom_range(span - 1));
        dec_rs2    = RW'($urandom_range(span - 1));
        dec_rd_wr  = ($urandom_range(4) != 0);
        dec_rs1_en = ($urandom_range(3) != 0);
        dec_rs2_en = ($urandom_range(2) != 0);
        dec_target = PCW'($urandom);
        unit_free  = NUNIT'($urandom);
        model_pick();
        r = $urandom_range(NREG - 1);
        cmp_valid = m_busy[r] && ($urandom_range(1) == 1);
        cmp_reg   = RW'(r);
        if (e_v && m_dst[e_i] != 0 && $urandom_range(3) == 0) begin
            // same-edge completion and issue on one register (R2)
            for (int b = NREG - 1; b >= 0; b--) if (m_dst[e_i][b]) cmp_reg = RW'(b);
            cmp_valid = 1;
        end
        br_done     = m_hold && m_brx && ($urandom_range(3) == 0);
        br_redirect = ($urandom_range(1) == 1);
        br_target   = PCW'($urandom);
        exp_rdy = !m_hold && ((m_cnt - int'(e_v)) < DEPTH);
        #2;
        check(iss_valid == e_v, e_v ? "R3/R4/R5/R11 iss_valid" : "R7 iss_valid idle", iss_valid, e_v);
        if (e_v) begin
            check(iss_slot == IW'(e_i), "R6 iss_slot", iss_slot, e_i);
            check(iss_pc == m_pc[e_i], "R6/R8 iss_pc order", iss_pc, m_pc[e_i]);
            check(iss_is_br == m_br[e_i] && iss_unit == m_unit[e_i], "R1/R6 iss fields",
                  {iss_is_br, iss_unit}, {m_br[e_i], m_unit[e_i]});
        end
        check(dec_ready == exp_rdy, "R8/R10 dec_ready", dec_ready, exp_rdy);
        check(fetch_pc == m_fpc, "R8/R9/R10 fetch_pc", fetch_pc, m_fpc);
        check(reg_pending == m_busy, "R2 reg_pending", reg_pending, m_busy);
        // advance model to the next edge
        acc = dec_valid && exp_rdy;
        nsrc = '0; ndst = '0;
        if (dec_rs1_en) nsrc[dec_rs1] = 1;
        if (dec_rs2_en) nsrc[dec_rs2] = 1;
        if ((dec_kind == 2'b00 || dec_kind == 2'b11) && dec_rd_wr) ndst[dec_rd] = 1;
        clr = '0;
        if (cmp_valid) clr[cmp_reg] = 1;
        m_busy = (m_busy & ~clr) | (e_v ? m_dst[e_i] : '0);
        if (e_v) begin
            if (m_br[e_i]) m_brx = 1;
            for (int i = e_i; i < DEPTH - 1; i++) begin
                m_src[i] = m_src[i+1]; m_dst[i] = m_dst[i+1];
                m_unit[i] = m_unit[i+1]; m_br[i] = m_br[i+1]; m_pc[i] = m_pc[i+1];
            end
            m_cnt--;
        end
        if (acc && dec_kind != 2'b10) begin
            m_src[m_cnt] = nsrc; m_dst[m_cnt] = ndst; m_unit[m_cnt] = dec_unit;
            m_br[m_cnt] = (dec_kind == 2'b01); m_pc[m_cnt] = m_fpc;
            m_cnt++;
        end
        if (m_hold) begin
            if (br_done) begin
                m_hold = 0; m_brx = 0;
                if (br_redirect) m_fpc = br_target;
            end
        end else if (acc) begin
            m_fpc = (dec_kind == 2'b10) ? dec_target : m_fpc + 1'b1;
            if (dec_kind == 2'b01) begin m_hold = 1; m_brx = 0; end
        end
    endtask

    initial begin
        m_cnt = 0; m_busy = '0; m_fpc = '0; m_hold = 0; m_brx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        check(iss_valid == 0, "R12 iss_valid after reset", iss_valid, 0);
        check(dec_ready == 1, "R12 dec_ready after reset", dec_ready, 1);
        check(fetch_pc == 0, "R12 fetch_pc after reset", fetch_pc, 0);
        check(reg_pending == 0, "R12 reg_pending after reset", reg_pending, 0);
        for (int p = 0; p < 4000; p++) step(3, 5);
        for (int p = 0; p < 4000; p++) step(NREG, 10);
        for (int p = 0; p < 4000; p++) step(2, 20);
        for (int p = 0; p < 2000; p++) step(NREG, 2);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1_900_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R8 run hung actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule